// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Alternate Pin Functions

This block is a 7-bit general-purpose port whose pins have no direction register. A pin holding 0 in the port data register is driven strongly low. A pin holding 1 is held high only by a weak pull-up, so an outside source can pull it down and the CPU can read the level back. A short strong-high pulse follows every 0-to-1 write so that the rising edge is fast. The CPU reaches the port data register and a few control registers through a simple register bus: write enable, address and write data, with combinational read data.

Control bits hand single pins over to neighbouring blocks. Two pins can become analog inputs. Two pins can carry a half-frequency sync input and output. One pin can carry a self-test pattern, and only while free-running mode is active. Two pins can feed external interrupt inputs. A pin given to an input function stops all of its own drive, so it floats. A pin given to an output function is driven push-pull.

Top module: `qb_port_top`

## Requirements
- R1: After synchronous reset, every pin has pull-up 1, strong-low 0 and strong-high 0. ana_sel and irq_o are 0, and reads of addresses 0x18 and 0x1B return 0x00.
- R2: Writing the data register (address 0x01) with bit i = 0 makes pin i drive strong-low with no pull-up and no strong-high, from the clock edge of the write.
- R3: A write that changes data bit i from 0 to 1 gives pin i strong-high for exactly the one cycle after the write edge, with the pull-up on. A write of 1 over 1 gives no strong-high.
- R4: A read of address 0x01 returns {1'b0, pin_in} as it was two clock edges earlier.
- R5: Clearing bit 0 (or bit 1) of write-only address 0x10 (reset 0xFF) gives pin 0 (or pin 1) to analog input 0 (or 1): ana_sel bit set, and all three drives of the pin off regardless of the data register.
- R6: Clearing bit 6 of write-only address 0x0C (reset 0xFF) drives pin 2 push-pull from half_out_val and floats pin 3, whose level appears on half_in_o. half_in_o is 0 while the bit is set.
- R7: Pin 4 is driven push-pull from pat_val only when bit 7 of address 0x0C is 0 and free_run_act is 1. If either condition is missing, it stays an ordinary port pin.
- R8: Setting bit 1 of address 0x18 floats pin 5 and routes its level to irq_o[0]. Setting bit 0 of address 0x1B does the same for pin 6 and irq_o[1]. A disabled irq_o bit reads 0.
- R9: Addresses 0x18 and 0x1B read back the full byte last written. Reads of 0x0C, 0x10 and unmapped addresses return 0x00.
- R10: No pin ever has strong-low on together with its pull-up or its strong-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| free_run_act | input | 1 | Free-running sync mode is active |
| pat_val | input | 1 | Self-test pattern level |
| half_out_val | input | 1 | Half-frequency output level |
| pin_in | input | 7 | Sensed pin levels |
| pin_drv_lo | output | 7 | Strong-low drive per pin |
| pin_pu | output | 7 | Weak pull-up enable per pin |
| pin_drv_hi | output | 7 | Strong-high drive per pin |
| ana_sel | output | 2 | Pins 0/1 given to analog inputs |
| half_in_o | output | 1 | Half-frequency input from pin 3 |
| irq_o | output | 2 | External interrupt inputs from pins 5/6 |

## Verification
A corrupted data or control bit shows on the drive outputs of the affected pin in the cycle right after the write that set it. For that reason every register write is followed by a comparison of all 21 drive bits against an independent model. A stuck or lingering boost flop shows as a strong-high that lasts longer than one cycle, or one that appears on a write of 1 over 1. A missing or extra synchronizer stage shifts the read-back of pin levels by one cycle, and the bench detects this by changing the pins between reads.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    localparam int PW = 7;
    localparam int AW = 5;
    localparam int DW = 8;

    localparam logic [AW-1:0] A_DATA = 5'h01;
    localparam logic [AW-1:0] A_FREE = 5'h0C;
    localparam logic [AW-1:0] A_ANA  = 5'h10;
    localparam logic [AW-1:0] A_IE0  = 5'h18;
    localparam logic [AW-1:0] A_IE1  = 5'h1B;

    localparam int B_PAT  = 7;
    localparam int B_HALF = 6;
    localparam int B_IE0  = 1;
    localparam int B_IE1  = 0;

    localparam int P_ANA0 = 0;
    localparam int P_ANA1 = 1;
    localparam int P_HOUT = 2;
    localparam int P_HIN  = 3;
    localparam int P_PAT  = 4;
    localparam int P_IRQ0 = 5;
    localparam int P_IRQ1 = 6;

    typedef enum logic [1:0] {
        MODE_PORT  = 2'd0,
        MODE_FLOAT = 2'd1,
        MODE_PUSH  = 2'd2
    } pin_mode_t;

    typedef struct packed {
        logic lo;
        logic pu;
        logic hi;
    } pin_drv_t;

    typedef struct packed {
        logic [PW-1:0] data;
        logic [1:0]    ana_n;
        logic          pat_n;
        logic          half_n;
        logic [DW-1:0] ie0;
        logic [DW-1:0] ie1;
    } ctrl_t;

    function automatic pin_drv_t drive_of(pin_mode_t m, logic d, logic boost, logic pv);
        pin_drv_t r;
        case (m)
            MODE_PORT:  r = '{lo: ~d, pu: d, hi: d & boost};
            MODE_PUSH:  r = '{lo: ~pv, pu: 1'b0, hi: pv};
            default:    r = '{lo: 1'b0, pu: 1'b0, hi: 1'b0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/qbp_regs.sv
module qbp_regs
    import qbp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic [PW-1:0] boost
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.data   <= '1;
            ctrl.ana_n  <= '1;
            ctrl.pat_n  <= 1'b1;
            ctrl.half_n <= 1'b1;
            ctrl.ie0    <= '0;
            ctrl.ie1    <= '0;
            boost       <= '0;
        end else begin
            boost <= '0;
            if (we) begin
                case (addr)
                    A_DATA: begin
                        ctrl.data <= wdata[PW-1:0];
                        boost     <= wdata[PW-1:0] & ~ctrl.data;
                    end
                    A_FREE: begin
                        ctrl.pat_n  <= wdata[B_PAT];
                        ctrl.half_n <= wdata[B_HALF];
                    end
                    A_ANA:  ctrl.ana_n <= wdata[1:0];
                    A_IE0:  ctrl.ie0 <= wdata;
                    A_IE1:  ctrl.ie1 <= wdata;
                    default: ;
                endcase
            end
        end
    end

    AST_RESET_DATA: assert property (@(posedge clk) $rose(rst) |=> ctrl.data == '1 && ctrl.ie0 == '0); // R1
    AST_BOOST_SHORT: assert property (@(posedge clk) disable iff (rst) (boost != '0) |=> (boost & $past(boost)) == '0); // R3
    AST_BOOST_HIGH: assert property (@(posedge clk) disable iff (rst) (boost & ~ctrl.data) == '0); // R3
endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) st[s] <= '0;
        end else begin
            st[0] <= d;
            for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/qbp_pin_cell.sv
module qbp_pin_cell
    import qbp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_t mode,
    input  logic      data,
    input  logic      boost,
    input  logic      push_val,
    output pin_drv_t  drv
);
    assign drv = drive_of(mode, data, boost, push_val);

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst) !(drv.lo && (drv.pu || drv.hi))); // R10
endmodule

// File: rtl/qb_port_top.sv
module qb_port_top
    import qbp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          free_run_act,
    input  logic          pat_val,
    input  logic          half_out_val,
    input  logic [PW-1:0] pin_in,
    output logic [PW-1:0] pin_drv_lo,
    output logic [PW-1:0] pin_pu,
    output logic [PW-1:0] pin_drv_hi,
    output logic [1:0]    ana_sel,
    output logic          half_in_o,
    output logic [1:0]    irq_o
);
    ctrl_t         ctrl;
    logic [PW-1:0] boost;
    logic [PW-1:0] pin_sync;
    pin_mode_t     mode [PW];
    logic [PW-1:0] push_val;
    logic          half_on, pat_on, ie0_on, ie1_on;

    qbp_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .ctrl(ctrl), .boost(boost)
    );

    qbp_sync #(.W(PW), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
    );

    assign half_on = ~ctrl.half_n;
    assign pat_on  = ~ctrl.pat_n & free_run_act;
    assign ie0_on  = ctrl.ie0[B_IE0];
    assign ie1_on  = ctrl.ie1[B_IE1];

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            mode[i]     = MODE_PORT;
            push_val[i] = 1'b0;
        end
        if (!ctrl.ana_n[0]) mode[P_ANA0] = MODE_FLOAT;
        if (!ctrl.ana_n[1]) mode[P_ANA1] = MODE_FLOAT;
        if (half_on) begin
            mode[P_HOUT]     = MODE_PUSH;
            push_val[P_HOUT] = half_out_val;
            mode[P_HIN]      = MODE_FLOAT;
        end
        if (pat_on) begin
            mode[P_PAT]     = MODE_PUSH;
            push_val[P_PAT] = pat_val;
        end
        if (ie0_on) mode[P_IRQ0] = MODE_FLOAT;
        if (ie1_on) mode[P_IRQ1] = MODE_FLOAT;
    end

    for (genvar g = 0; g < PW; g++) begin : g_pin
        pin_drv_t d;
        qbp_pin_cell u_cell (
            .clk(clk), .rst(rst), .mode(mode[g]), .data(ctrl.data[g]),
            .boost(boost[g]), .push_val(push_val[g]), .drv(d)
        );
        assign pin_drv_lo[g] = d.lo;
        assign pin_pu[g]     = d.pu;
        assign pin_drv_hi[g] = d.hi;
    end

    assign ana_sel   = ~ctrl.ana_n;
    assign half_in_o = half_on & pin_in[P_HIN];
    assign irq_o     = {ie1_on & pin_in[P_IRQ1], ie0_on & pin_in[P_IRQ0]};

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = {{(DW-PW){1'b0}}, pin_sync};
            A_IE0:   bus_rdata = ctrl.ie0;
            A_IE1:   bus_rdata = ctrl.ie1;
            default: bus_rdata = '0;
        endcase
    end

    AST_ANA_FLOAT: assert property (@(posedge clk) disable iff (rst) ana_sel[0] |-> !(pin_drv_lo[0] || pin_pu[0] || pin_drv_hi[0])); // R5
    AST_IRQ_FLOAT: assert property (@(posedge clk) disable iff (rst) irq_o[0] |-> !(pin_drv_lo[5] || pin_pu[5] || pin_drv_hi[5])); // R8
endmodule

// File: tb/sim_qb_port_top.sv
module sim_qb_port_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       free_run_act = 1'b0, pat_val = 1'b0, half_out_val = 1'b0;
    logic [6:0] pin_in = '0;
    logic [6:0] pin_drv_lo, pin_pu, pin_drv_hi;
    logic [1:0] ana_sel, irq_o;
    logic       half_in_o;

    int n_cmp = 0, n_bad = 0;

    logic [6:0] m_data, m_boost;
    logic [1:0] m_ana_n;
    logic       m_pat_n, m_half_n;
    logic [7:0] m_ie0, m_ie1;

    always #5 clk = ~clk;

    qb_port_top u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [20:0] exp_pins();
        logic [6:0] lo, pu, hi;
        for (int i = 0; i < 7; i++) begin
            lo[i] = ~m_data[i]; pu[i] = m_data[i]; hi[i] = m_data[i] & m_boost[i];
        end
        for (int i = 0; i < 2; i++)
            if (!m_ana_n[i]) begin lo[i] = 0; pu[i] = 0; hi[i] = 0; end
        if (!m_half_n) begin
            lo[2] = ~half_out_val; pu[2] = 0; hi[2] = half_out_val;
            lo[3] = 0; pu[3] = 0; hi[3] = 0;
        end
        if (!m_pat_n && free_run_act) begin
            lo[4] = ~pat_val; pu[4] = 0; hi[4] = pat_val;
        end
        if (m_ie0[1]) begin lo[5] = 0; pu[5] = 0; hi[5] = 0; end
        if (m_ie1[0]) begin lo[6] = 0; pu[6] = 0; hi[6] = 0; end
        return {lo, pu, hi};
    endfunction

    function automatic logic [3:0] exp_side();
        return {(~m_half_n) & pin_in[3], (m_ie1[0] & pin_in[6]), (m_ie0[1] & pin_in[5]), 1'b0};
    endfunction

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
        m_boost = '0;
        case (a)
            5'h01: begin m_boost = d[6:0] & ~m_data; m_data = d[6:0]; end
            5'h0C: begin m_pat_n = d[7]; m_half_n = d[6]; end
            5'h10: m_ana_n = d[1:0];
            5'h18: m_ie0 = d;
            5'h1B: m_ie1 = d;
            default: ;
        endcase
    endtask

    task automatic idle();
        @(negedge clk);
        m_boost = '0;
    endtask

    function automatic logic [20:0] obs();
        return {pin_drv_lo, pin_pu, pin_drv_hi};
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [6:0] pa, pb;
        logic [4:0] addrs [6];
        void'($urandom(32'h5EED_1234));
        addrs = '{5'h01, 5'h0C, 5'h10, 5'h18, 5'h1B, 5'h01};
        m_data = '1; m_boost = '0; m_ana_n = '1; m_pat_n = 1; m_half_n = 1; m_ie0 = 0; m_ie1 = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check("R1 pins", obs(), {7'h00, 7'h7F, 7'h00});
        check("R1 ana_sel", ana_sel, 0);
        check("R1 irq_o", irq_o, 0);
        bus_addr = 5'h18; #1 check("R1 rd18", bus_rdata, 0);
        bus_addr = 5'h1B; #1 check("R1 rd1B", bus_rdata, 0);

        // R2 drive low
        wr(5'h01, 8'h7E);
        check("R2 pin0 low", obs(), exp_pins());
        check("R2 lo0", pin_drv_lo[0], 1);
        // R3 boost one cycle
        wr(5'h01, 8'h7F);
        check("R3 hi0 pulse", pin_drv_hi, 7'h01);
        check("R3 pu0", pin_pu[0], 1);
        idle();
        check("R3 hi0 ends", pin_drv_hi, 7'h00);
        wr(5'h01, 8'h7F);
        check("R3 no boost 1 over 1", pin_drv_hi, 7'h00);

        // R4 readback timing
        bus_addr = 5'h01;
        pa = 7'h55; pin_in = pa;
        repeat (3) @(negedge clk);
        pb = 7'h2A; pin_in = pb;
        @(negedge clk);
        check("R4 stage1 old", bus_rdata, {1'b0, pa});
        @(negedge clk);
        check("R4 stage2 new", bus_rdata, {1'b0, pb});

        // R5 analog
        wr(5'h10, 8'hFE);
        check("R5 ana_sel", ana_sel, 2'b01);
        check("R5 pins", obs(), exp_pins());
        wr(5'h01, 8'h7C);
        check("R5 data ignored", obs(), exp_pins());
        wr(5'h10, 8'hFC);
        check("R5 both", {ana_sel, pin_drv_lo[1:0], pin_pu[1:0]}, {2'b11, 4'b0});
        wr(5'h10, 8'hFF);
        wr(5'h01, 8'h7F);

        // R6 half
        check("R6 half off", half_in_o, 0);
        wr(5'h0C, 8'hBF);
        half_out_val = 1; pin_in = 7'h08; #1;
        check("R6 pins hv1", obs(), exp_pins());
        check("R6 half_in", half_in_o, 1);
        half_out_val = 0; pin_in = 7'h00; #1;
        check("R6 pins hv0", obs(), exp_pins());
        check("R6 half_in0", half_in_o, 0);
        wr(5'h0C, 8'hFF);

        // R7 pattern needs both conditions
        pat_val = 0;
        free_run_act = 0;
        wr(5'h0C, 8'h7F);
        check("R7 no free run", {pin_drv_lo[4], pin_pu[4]}, 2'b01);
        free_run_act = 1; #1;
        check("R7 both", {pin_drv_lo[4], pin_pu[4], pin_drv_hi[4]}, 3'b100);
        pat_val = 1; #1;
        check("R7 pat1", {pin_drv_lo[4], pin_pu[4], pin_drv_hi[4]}, 3'b001);
        wr(5'h0C, 8'hFF);
        check("R7 bit set", {pin_drv_lo[4], pin_pu[4], pin_drv_hi[4]}, 3'b010);
        free_run_act = 0;

        // R8 interrupts, R9 readback
        wr(5'h18, 8'h02);
        pin_in = 7'h20; #1;
        check("R8 irq0", irq_o, 2'b01);
        check("R8 pin5 float", {pin_drv_lo[5], pin_pu[5], pin_drv_hi[5]}, 0);
        wr(5'h1B, 8'hA5);
        pin_in = 7'h40; #1;
        check("R8 irq1", irq_o, 2'b10);
        bus_addr = 5'h18; #1 check("R9 rd18", bus_rdata, 8'h02);
        bus_addr = 5'h1B; #1 check("R9 rd1B", bus_rdata, 8'hA5);
        bus_addr = 5'h0C; #1 check("R9 rd0C", bus_rdata, 0);
        bus_addr = 5'h10; #1 check("R9 rd10", bus_rdata, 0);
        bus_addr = 5'h07; #1 check("R9 unmapped", bus_rdata, 0);
        wr(5'h18, 8'h00);
        wr(5'h1B, 8'h00);

        // random mix (R2 R3 R5 R6 R7 R8 R10)
        for (int k = 0; k < 300; k++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = addrs[$urandom % 6];
            d = 8'($urandom);
            free_run_act = 1'($urandom); pat_val = 1'($urandom);
            half_out_val = 1'($urandom); pin_in = 7'($urandom);
            wr(a, d);
            check("R2 R3 rnd pins", obs(), exp_pins());
            check("R6 R8 rnd side", {half_in_o, irq_o, 1'b0}, exp_side());
            check("R10 rnd", |(pin_drv_lo & (pin_pu | pin_drv_hi)), 0);
            idle();
            check("R3 rnd after", obs(), exp_pins());
        end

        // random readback R4
        bus_addr = 5'h01;
        for (int k = 0; k < 20; k++) begin
            pa = 7'($urandom);
            pin_in = pa;
            repeat (2) @(negedge clk);
            check("R4 rnd read", bus_rdata, {1'b0, pa});
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule